// File: doc/BRIEF.md
# Macro Call Gatherer

This block watches a command-processor register-write bus for writes that address the macro region of the method space. A macro call uses a pair of neighbouring methods. The even method opens the call. The odd method after it carries any further argument words. Each accepted argument word goes into a parameter store. When the word flagged as last in its batch arrives, the block works out a slot number from the method index. It reads the start position stored in that slot of a bind table, then signals the executor with a one-cycle start pulse. The pulse carries the start position and the number of parameter words.

The same bus also maintains two pointers that feed the macro machinery. One is the bind-table write pointer: each bind-data write stores a start position at the pointer and then advances it. The other is the code-upload address: each code-data write is forwarded to the microcode store at that address and then advances it. The executor reads parameters through a read port and ends its run with a done pulse. Until that pulse, the block stays busy and will not start another call.

Top module: `macro_call_gather`

## Requirements
- R1: After reset, busy, exec_start, seq_err, ovf and code_we are low, and no call is in progress. Reset clears the pointers to zero. Reset leaves the bind-table contents unchanged.
- R2: A write with method index at or above MACRO_BASE (default 0xE00) is a macro write. A write below MACRO_BASE that is not one of the four control methods has no effect: code_we stays low and busy does not rise.
- R3: With no call in progress and busy low, a macro write to an even method opens a call and latches that method. An odd method in that state sets seq_err and is discarded.
- R4: While a call is in progress, only the latched method plus one is accepted. Any other write, including a control method, sets seq_err and is discarded.
- R5: Each accepted word, the opening word included, is stored in arrival order starting at slot 0. prm_rd_data returns slot prm_rd_addr one cycle after the address is presented.
- R6: An accepted word with wr_last high ends the call. The slot number is ((method − MACRO_BASE) >> 1) mod BIND_DEPTH. Busy rises the cycle after that write. exec_start pulses for exactly one cycle on the following cycle, with exec_pos set to the slot's stored position and exec_count set to the number of words stored.
- R7: Once a call has ended, the latched method returns to zero and the word count restarts. The next call counts from its own opening word and needs a fresh even method.
- R8: A write to M_BIND_PTR (default 0x0A2) loads the bind pointer. A write to M_BIND_DATA (default 0x0A3) stores wr_data[PW-1:0] at the pointer and then advances the pointer by one, wrapping at BIND_DEPTH.
- R9: A write to M_UP_ADDR (default 0x0A0) loads the upload address. A write to M_UP_DATA (default 0x0A1) produces a one-cycle code_we with code_addr set to the current address and code_data set to wr_data, then advances the address, wrapping at 2^CAW.
- R10: A word accepted when PBUF_DEPTH words are already stored sets ovf and is not stored. exec_count saturates at PBUF_DEPTH, and the call still ends on its last word.
- R11: Busy stays high from the end of a call until exec_done. A macro write that arrives while busy sets seq_err, is discarded, and leaves the stored parameters unchanged.
- R12: seq_err and ovf stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A register write is present this cycle |
| wr_method | input | MW | Method index of the write |
| wr_data | input | DW | Argument word |
| wr_last | input | 1 | Final word of the current batch |
| exec_done | input | 1 | Executor finished; pulse |
| prm_rd_addr | input | $clog2(PBUF_DEPTH) | Parameter slot to read |
| prm_rd_data | output | DW | Parameter word, one cycle after the address |
| exec_start | output | 1 | One-cycle start request to the executor |
| exec_pos | output | PW | Start position looked up in the bind table |
| exec_count | output | $clog2(PBUF_DEPTH+1) | Number of parameter words |
| busy | output | 1 | A call has been handed off and is not yet done |
| code_we | output | 1 | Microcode word write strobe |
| code_addr | output | CAW | Microcode word address |
| code_data | output | DW | Microcode word |
| seq_err | output | 1 | Sticky illegal-sequence flag |
| ovf | output | 1 | Sticky parameter-store overflow flag |

## Verification
The properties assume that the executor raises exec_done only while busy is high and after it has seen exec_start. They also assume that wr_valid is a clean, per-cycle qualifier. The stimulus pulses done only after checking the start pulse, and it drives every write for exactly one clock with a gap afterwards, so successive words never overlap. Writes that break the call sequence or collide with a running call are applied on purpose. The checks then confirm that these writes leave the outputs and the parameter store untouched, and that they only raise the sticky error flag.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_MACRO,
    K_UP_ADDR,
    K_UP_DATA,
    K_BIND_PTR,
    K_BIND_DATA
  } wr_kind_e;
endpackage

// File: rtl/mtc_decode.sv
module mtc_decode
  import mtc_pkg::*;
#(
  parameter int MW = 13,
  parameter logic [MW-1:0] BASE      = 13'hE00,
  parameter logic [MW-1:0] UP_ADDR   = 13'h0A0,
  parameter logic [MW-1:0] UP_DATA   = 13'h0A1,
  parameter logic [MW-1:0] BIND_PTR  = 13'h0A2,
  parameter logic [MW-1:0] BIND_DATA = 13'h0A3
) (
  input  logic [MW-1:0] method,
  output wr_kind_e      kind
);
  always_comb begin
    if (method >= BASE)           kind = K_MACRO;
    else if (method == UP_ADDR)   kind = K_UP_ADDR;
    else if (method == UP_DATA)   kind = K_UP_DATA;
    else if (method == BIND_PTR)  kind = K_BIND_PTR;
    else if (method == BIND_DATA) kind = K_BIND_DATA;
    else                          kind = K_NONE;
  end
endmodule

// File: rtl/mtc_step_ptr.sv
module mtc_step_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= q + 1'b1;
  end
endmodule

// File: rtl/mtc_param_buf.sv
module mtc_param_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic [CW-1:0] cnt,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  assign full = (cnt == CW'(DEPTH));

  // storage without reset so that a block RAM can hold it
  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[AW-1:0]] <= push_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (push && !full)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mtc_bind_table.sv
module mtc_bind_table #(
  parameter int PW    = 12,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [PW-1:0] rd_data
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/macro_call_gather.sv
module macro_call_gather
  import mtc_pkg::*;
#(
  parameter int MW          = 13,
  parameter int DW          = 32,
  parameter int PW          = 12,
  parameter int CAW         = 12,
  parameter int PBUF_DEPTH  = 32,
  parameter int BIND_DEPTH  = 16,
  parameter logic [MW-1:0] MACRO_BASE  = 13'hE00,
  parameter logic [MW-1:0] M_UP_ADDR   = 13'h0A0,
  parameter logic [MW-1:0] M_UP_DATA   = 13'h0A1,
  parameter logic [MW-1:0] M_BIND_PTR  = 13'h0A2,
  parameter logic [MW-1:0] M_BIND_DATA = 13'h0A3,
  localparam int PAW = $clog2(PBUF_DEPTH),
  localparam int PCW = $clog2(PBUF_DEPTH + 1),
  localparam int BIW = $clog2(BIND_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_valid,
  input  logic [MW-1:0]  wr_method,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_last,
  input  logic           exec_done,
  input  logic [PAW-1:0] prm_rd_addr,
  output logic [DW-1:0]  prm_rd_data,
  output logic           exec_start,
  output logic [PW-1:0]  exec_pos,
  output logic [PCW-1:0] exec_count,
  output logic           busy,
  output logic           code_we,
  output logic [CAW-1:0] code_addr,
  output logic [DW-1:0]  code_data,
  output logic           seq_err,
  output logic           ovf
);
  wr_kind_e       kind;
  logic [MW-1:0]  cur_q;
  logic           busy_q, fire_q, start_q, err_q, ovf_q;
  logic [PW-1:0]  pos_q;
  logic [PCW-1:0] count_q;
  logic           cwe_q;
  logic [CAW-1:0] caddr_q;
  logic [DW-1:0]  cdata_q;

  logic           in_prog, is_macro, start_ok, arg_ok, take, seq_bad, ctrl;
  logic           dispatch, buf_full, spill;
  logic [PCW-1:0] buf_cnt;
  logic [MW-1:0]  entry_off;
  logic [BIW-1:0] tbl_idx, bind_ptr;
  logic [PW-1:0]  tbl_pos;
  logic [CAW-1:0] up_addr;

  mtc_decode #(
    .MW(MW), .BASE(MACRO_BASE), .UP_ADDR(M_UP_ADDR), .UP_DATA(M_UP_DATA),
    .BIND_PTR(M_BIND_PTR), .BIND_DATA(M_BIND_DATA)
  ) u_dec (
    .method (wr_method),
    .kind   (kind)
  );

  assign in_prog  = (cur_q != '0);
  assign is_macro = wr_valid && (kind == K_MACRO);
  assign start_ok = is_macro && !in_prog && !busy_q && !wr_method[0];
  assign arg_ok   = wr_valid && in_prog && (wr_method == cur_q + MW'(1));
  assign take     = start_ok || arg_ok;
  assign seq_bad  = (is_macro && !in_prog && !start_ok) ||
                    (wr_valid && in_prog && !arg_ok);
  assign ctrl     = wr_valid && !in_prog;
  assign dispatch = take && wr_last;
  assign spill    = take && buf_full;

  assign entry_off = (wr_method - MACRO_BASE) >> 1;
  assign tbl_idx   = BIW'(entry_off % MW'(BIND_DEPTH));

  mtc_param_buf #(.DW(DW), .DEPTH(PBUF_DEPTH)) u_pbuf (
    .clk       (clk),
    .rst       (rst),
    .clr       (fire_q),
    .push      (take),
    .push_data (wr_data),
    .full      (buf_full),
    .cnt       (buf_cnt),
    .rd_addr   (prm_rd_addr),
    .rd_data   (prm_rd_data)
  );

  mtc_step_ptr #(.W(BIW)) u_bptr (
    .clk      (clk),
    .rst      (rst),
    .load     (ctrl && kind == K_BIND_PTR),
    .load_val (wr_data[BIW-1:0]),
    .step     (ctrl && kind == K_BIND_DATA),
    .q        (bind_ptr)
  );

  mtc_bind_table #(.PW(PW), .DEPTH(BIND_DEPTH)) u_tbl (
    .clk     (clk),
    .wr_en   (ctrl && kind == K_BIND_DATA),
    .wr_idx  (bind_ptr),
    .wr_data (wr_data[PW-1:0]),
    .rd_idx  (tbl_idx),
    .rd_data (tbl_pos)
  );

  mtc_step_ptr #(.W(CAW)) u_uptr (
    .clk      (clk),
    .rst      (rst),
    .load     (ctrl && kind == K_UP_ADDR),
    .load_val (wr_data[CAW-1:0]),
    .step     (ctrl && kind == K_UP_DATA),
    .q        (up_addr)
  );

  // call sequencing and handoff
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      busy_q  <= 1'b0;
      fire_q  <= 1'b0;
      start_q <= 1'b0;
      pos_q   <= '0;
      count_q <= '0;
      err_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      fire_q  <= dispatch;
      start_q <= fire_q;
      if (dispatch)      cur_q <= '0;
      else if (start_ok) cur_q <= wr_method;
      if (dispatch)                    busy_q <= 1'b1;
      else if (exec_done && !fire_q)   busy_q <= 1'b0;
      if (fire_q) begin
        pos_q   <= tbl_pos;
        count_q <= buf_cnt;
      end
      if (seq_bad) err_q <= 1'b1;
      if (spill)   ovf_q <= 1'b1;
    end
  end

  // microcode upload port
  always_ff @(posedge clk) begin
    if (rst) begin
      cwe_q   <= 1'b0;
      caddr_q <= '0;
      cdata_q <= '0;
    end else begin
      cwe_q <= ctrl && (kind == K_UP_DATA);
      if (ctrl && kind == K_UP_DATA) begin
        caddr_q <= up_addr;
        cdata_q <= wr_data;
      end
    end
  end

  assign exec_start = start_q;
  assign exec_pos   = pos_q;
  assign exec_count = count_q;
  assign busy       = busy_q;
  assign code_we    = cwe_q;
  assign code_addr  = caddr_q;
  assign code_data  = cdata_q;
  assign seq_err    = err_q;
  assign ovf        = ovf_q;
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int MW = 13,
  parameter int PCW = 6,
  parameter int CAW = 12,
  parameter int PBUF_DEPTH = 32,
  parameter logic [MW-1:0] MACRO_BASE = 13'hE00
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_valid,
  input logic [MW-1:0]  wr_method,
  input logic           wr_last,
  input logic           exec_done,
  input logic           exec_start,
  input logic [PCW-1:0] exec_count,
  input logic           busy,
  input logic           code_we,
  input logic [CAW-1:0] code_addr,
  input logic           seq_err,
  input logic           ovf
);
  p_start_busy_r11: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> busy);

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);

  p_busy_origin_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_valid && wr_last && (wr_method >= MACRO_BASE)));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !exec_done) |=> busy);

  p_count_range_r10: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> (exec_count != '0) && (exec_count <= PCW'(PBUF_DEPTH)));

  p_code_step_r9: assert property (@(posedge clk) disable iff (rst)
    (code_we && $past(code_we)) |-> (code_addr == CAW'($past(code_addr) + 1)));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);

  p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

bind macro_call_gather mtc_checker #(
  .MW(MW), .PCW(PCW), .CAW(CAW), .PBUF_DEPTH(PBUF_DEPTH), .MACRO_BASE(MACRO_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_method  (wr_method),
  .wr_last    (wr_last),
  .exec_done  (exec_done),
  .exec_start (exec_start),
  .exec_count (exec_count),
  .busy       (busy),
  .code_we    (code_we),
  .code_addr  (code_addr),
  .seq_err    (seq_err),
  .ovf        (ovf)
);

// File: tb/macro_call_gather_test.sv
module macro_call_gather_test;
  localparam logic [12:0] UPA = 13'h0A0, UPD = 13'h0A1, BPT = 13'h0A2, BDT = 13'h0A3;

  // method, data, expected code_we, expected code_addr
  localparam logic [57:0] VEC [8] = '{
    {UPA,   32'h0000_0010, 1'b0, 12'h000},
    {UPD,   32'hAAAA_0001, 1'b1, 12'h010},
    {UPD,   32'hBBBB_0002, 1'b1, 12'h011},
    {13'h0123, 32'h0000_0005, 1'b0, 12'h000},
    {UPD,   32'hCCCC_0003, 1'b1, 12'h012},
    {UPA,   32'h0000_0FFF, 1'b0, 12'h000},
    {UPD,   32'h0000_0011, 1'b1, 12'hFFF},
    {UPD,   32'h0000_0022, 1'b1, 12'h000}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_method = '0;
  logic [31:0] wr_data = '0;
  logic        wr_last = 1'b0;
  logic        exec_done = 1'b0;
  logic [4:0]  prm_rd_addr = '0;
  logic [31:0] prm_rd_data;
  logic        exec_start;
  logic [11:0] exec_pos;
  logic [5:0]  exec_count;
  logic        busy, code_we, seq_err, ovf;
  logic [11:0] code_addr;
  logic [31:0] code_data;

  macro_call_gather uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_method(wr_method),
    .wr_data(wr_data), .wr_last(wr_last), .exec_done(exec_done),
    .prm_rd_addr(prm_rd_addr), .prm_rd_data(prm_rd_data),
    .exec_start(exec_start), .exec_pos(exec_pos), .exec_count(exec_count),
    .busy(busy), .code_we(code_we), .code_addr(code_addr), .code_data(code_data),
    .seq_err(seq_err), .ovf(ovf)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [12:0] m, input logic [31:0] d, input logic l);
    @(negedge clk);
    wr_valid = 1'b1; wr_method = m; wr_data = d; wr_last = l;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic rdp(input int idx, output logic [31:0] v);
    @(negedge clk);
    prm_rd_addr = idx[4:0];
    @(posedge clk); #1;
    v = prm_rd_data;
  endtask

  // call right after the last word was written
  task automatic see_start(input string req, input logic [11:0] pos, input bit chkpos,
                           input logic [5:0] cnt);
    chk(req, {31'd0, busy}, 32'd1);
    chk(req, {31'd0, exec_start}, 32'd0);
    @(posedge clk); #1;
    chk(req, {31'd0, exec_start}, 32'd1);
    if (chkpos) chk(req, {20'd0, exec_pos}, {20'd0, pos});
    chk(req, {26'd0, exec_count}, {26'd0, cnt});
    @(posedge clk); #1;
    chk(req, {31'd0, exec_start}, 32'd0);
  endtask

  task automatic done_exec();
    @(negedge clk); exec_done = 1'b1;
    @(posedge clk); #1; exec_done = 1'b0;
    chk("R11", {31'd0, busy}, 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", {27'd0, busy, exec_start, seq_err, ovf, code_we}, 32'd0);

    // R9 / R2: upload vectors
    for (int i = 0; i < 8; i++) begin
      logic [57:0] e;
      e = VEC[i];
      put(e[57:45], e[44:13], 1'b0);
      chk(e[12] ? "R9" : "R2", {31'd0, code_we}, {31'd0, e[12]});
      if (e[12]) begin
        chk("R9", {20'd0, code_addr}, {20'd0, e[11:0]});
        chk("R9", code_data, e[44:13]);
      end
    end
    // R2: just below the macro range, flagged last, does nothing
    put(13'h0DFF, 32'h1, 1'b1);
    repeat (2) @(posedge clk); #1;
    chk("R2", {30'd0, busy, exec_start}, 32'd0);

    // R8: bind table setup, including wrap of the pointer
    put(BPT, 32'd0, 1'b0);
    put(BDT, 32'h100, 1'b0);
    put(BDT, 32'h111, 1'b0);
    put(BDT, 32'h122, 1'b0);
    put(BDT, 32'h133, 1'b0);
    put(BPT, 32'd15, 1'b0);
    put(BDT, 32'h7F0, 1'b0);
    put(BDT, 32'h200, 1'b0);

    // R6: single-word call, slot 1
    put(13'h0E02, 32'hDEAD_0001, 1'b1);
    see_start("R6", 12'h111, 1'b1, 6'd1);
    rdp(0, v); chk("R5", v, 32'hDEAD_0001);
    done_exec();

    // R5 / R7: three-word call, slot 2, count restarts
    put(13'h0E04, 32'hA0, 1'b0);
    put(13'h0E05, 32'hB1, 1'b0);
    chk("R6", {31'd0, busy}, 32'd0);
    put(13'h0E05, 32'hC2, 1'b1);
    see_start("R7", 12'h122, 1'b1, 6'd3);
    rdp(0, v); chk("R5", v, 32'hA0);
    rdp(1, v); chk("R5", v, 32'hB1);
    rdp(2, v); chk("R5", v, 32'hC2);
    done_exec();

    // R8: slot 0 was overwritten through the pointer wrap
    put(13'h0E00, 32'h5, 1'b1);
    see_start("R8", 12'h200, 1'b1, 6'd1);
    done_exec();
    // R6: slot number taken modulo the table depth (17 mod 16 = 1)
    put(13'h0E22, 32'h6, 1'b1);
    see_start("R6", 12'h111, 1'b1, 6'd1);
    done_exec();

    // R4: wrong method during a call is discarded
    put(13'h0E06, 32'h11, 1'b0);
    put(13'h0E09, 32'h22, 1'b1);
    chk("R4", {31'd0, seq_err}, 32'd1);
    chk("R4", {31'd0, busy}, 32'd0);
    put(UPD, 32'h33, 1'b0);
    chk("R4", {31'd0, code_we}, 32'd0);
    put(13'h0E07, 32'h44, 1'b1);
    see_start("R4", 12'h133, 1'b1, 6'd2);
    rdp(0, v); chk("R4", v, 32'h11);
    rdp(1, v); chk("R4", v, 32'h44);
    done_exec();
    chk("R12", {31'd0, seq_err}, 32'd1);

    // R3: odd method cannot open a call
    do_reset();
    #1;
    chk("R1", {31'd0, seq_err}, 32'd0);
    put(13'h0E07, 32'h55, 1'b1);
    chk("R3", {31'd0, seq_err}, 32'd1);
    chk("R3", {31'd0, busy}, 32'd0);
    put(13'h0E06, 32'h66, 1'b1);
    see_start("R3", 12'h133, 1'b1, 6'd1);
    done_exec();

    // R11: macro write while busy is discarded
    do_reset();
    put(13'h0E02, 32'h77, 1'b1);
    see_start("R11", 12'h111, 1'b1, 6'd1);
    put(13'h0E04, 32'h88, 1'b1);
    chk("R11", {31'd0, seq_err}, 32'd1);
    repeat (3) @(posedge clk); #1;
    chk("R11", {31'd0, exec_start}, 32'd0);
    chk("R11", {31'd0, busy}, 32'd1);
    rdp(0, v); chk("R11", v, 32'h77);
    done_exec();

    // R10: overflow of the parameter store
    do_reset();
    put(13'h0E02, 32'd0, 1'b0);
    for (int k = 1; k <= 33; k++) put(13'h0E03, k, k == 33);
    chk("R10", {31'd0, ovf}, 32'd1);
    see_start("R10", 12'h0, 1'b0, 6'd32);
    rdp(31, v); chk("R10", v, 32'd31);
    done_exec();
    put(13'h0E04, 32'h9, 1'b1);
    see_start("R12", 12'h122, 1'b1, 6'd1);
    chk("R12", {31'd0, ovf}, 32'd1);
    done_exec();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule